// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a pipelined synchronous memory that moves four data beats for each address it accepts. A single control input chooses between two actions on each enabled clock edge. When it is low, the block captures a fresh external address, provided the device is selected. When it is high, the block steps an internal two-bit beat counter, and that counter rewrites only the two least significant bits of the captured address.

A static order input picks how those two low bits move. Linear order counts upward from the starting value and wraps inside the group of four. Interleaved order combines the starting value with the beat count by exclusive-or. A global clock-enable input suspends the whole block. A deselect seen on a load edge cancels any burst in progress.

The outputs are the current full address and a flag that is high while a burst is live. The memory array, the data path and the output drivers sit outside this block.

Top module: `burst_seq_top`

## Requirements
- R1: While `rstN` is low, and immediately after it is released, `burstActive` is 0 and `curAddr` is 0.
- R2: The device counts as selected only when `enLowA` is 0, `enHigh` is 1 and `enLowB` is 0 at the same time.
- R3: On a rising edge with `clkEn`=1, `advNotLoad`=0 and the device selected, the next cycle shows `curAddr` equal to `extAddr` and `burstActive`=1, and the beat count restarts at 0.
- R4: On a rising edge with `clkEn`=1, `advNotLoad`=1 and `burstActive`=1, the beat count rises by one modulo 4. The upper address bits (all bits above bit 1) never change except on a load.
- R5: With `interleave`=0, `curAddr[1:0]` equals (start + beat) mod 4, where start is bits [1:0] of the loaded address. For example, start 2 gives 2,3,0,1.
- R6: With `interleave`=1, `curAddr[1:0]` equals start XOR beat. For example, start 1 gives 1,0,3,2.
- R7: After the fourth beat, further advances wrap back to the starting low bits and keep cycling through the same four values.
- R8: On a rising edge with `clkEn`=1, `advNotLoad`=0 and the device not selected, `burstActive` falls to 0 in the next cycle and `curAddr` keeps its value.
- R9: An advance (`clkEn`=1, `advNotLoad`=1) while `burstActive`=0 changes neither `curAddr` nor `burstActive`.
- R10: On a rising edge with `clkEn`=0, every register holds, whatever the other inputs are, including a load request with a new address.
- R11: `interleave` acts on `curAddr` without a clock: changing it in the middle of a burst immediately re-maps the current beat under the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | 1 lets the edge act; 0 freezes all state |
| advNotLoad | input | 1 | 0 loads `extAddr`; 1 advances the burst |
| enLowA | input | 1 | Select input, active low |
| enHigh | input | 1 | Select input, active high |
| enLowB | input | 1 | Select input, active low |
| interleave | input | 1 | Order select: 0 linear, 1 interleaved |
| extAddr | input | ADDR_W | External starting address |
| curAddr | output | ADDR_W | Address of the current beat |
| burstActive | output | 1 | High while a burst is live |

## Verification
The corner cases are these:
- Starting values that wrap in linear order but not in interleaved order (start 2 and start 1). A design that mixed up the two orders, or that let a linear carry ripple into bit 2, would show the wrong low bits or a corrupted upper field.
- More than four advances in one burst, which catches a counter that stops or runs past the group of four instead of wrapping.
- Each select input dropped on its own during a load. This shows whether a wrongly decoded enable leaves the burst alive.
- A load attempt made while the clock enable is low, and advances sent after a deselect. A design that ignored the freeze or the termination would move its address in those cycles.
- Toggling the order input partway through a burst, and long random runs against the behavioural model, which expose any registered or stale mode path.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from the control half to the address datapath.
  typedef struct packed {
    logic loadAddr;   // capture external address, restart beat count
    logic stepBeat;   // advance beat count by one
    logic setActive;  // burst becomes live
    logic clrActive;  // burst is cancelled
  } seqStrobes_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEn,
  input  logic        advNotLoad,
  input  logic        enLowA,
  input  logic        enHigh,
  input  logic        enLowB,
  output seqStrobes_t strobes,
  output logic        burstActive
);

  logic selected;
  logic activeReg;

  assign selected = ~enLowA & enHigh & ~enLowB;

  always_comb begin
    strobes = '0;
    if (clkEn) begin
      if (!advNotLoad) begin
        if (selected) begin
          strobes.loadAddr  = 1'b1;
          strobes.setActive = 1'b1;
        end else begin
          strobes.clrActive = 1'b1;
        end
      end else if (activeReg) begin
        strobes.stepBeat = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  activeReg <= 1'b0;
    else if (strobes.setActive) activeReg <= 1'b1;
    else if (strobes.clrActive) activeReg <= 1'b0;
  end

  assign burstActive = activeReg;

  // R8: a load edge without full select ends the burst
  p_deselect_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advNotLoad && (enLowA || !enHigh || enLowB)) |=> !burstActive);

  // R9: advancing while idle never starts a burst
  p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advNotLoad && !burstActive) |=> !burstActive);

  // R10: frozen edge keeps the active flag
  p_freeze_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(burstActive));

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] baseUpper;
  logic [BEAT_W-1:0]  startLow;
  logic [BEAT_W-1:0]  beatCnt;
  logic [BEAT_W-1:0]  linearLow;
  logic [BEAT_W-1:0]  xorLow;
  logic [BEAT_W-1:0]  beatLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseUpper <= '0;
      startLow  <= '0;
      beatCnt   <= '0;
    end else if (strobes.loadAddr) begin
      baseUpper <= extAddr[ADDR_W-1:BEAT_W];
      startLow  <= extAddr[BEAT_W-1:0];
      beatCnt   <= '0;
    end else if (strobes.stepBeat) begin
      beatCnt   <= beatCnt + 1'b1;
    end
  end

  // Linear order: add inside the low field only, so the carry is dropped.
  assign linearLow = startLow + beatCnt;

  // Interleaved order: one XOR per low address bit.
  for (genvar i = 0; i < BEAT_W; i++) begin : g_xorBit
    assign xorLow[i] = startLow[i] ^ beatCnt[i];
  end

  assign beatLow = interleave ? xorLow : linearLow;
  assign curAddr = {baseUpper, beatLow};

  // R4: each step moves the beat count by exactly one, wrapping
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepBeat |=> beatCnt == BEAT_W'($past(beatCnt) + 1));

  // R4: upper field only moves on a load
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAddr |=> $stable(baseUpper) && $stable(startLow));

  // R3: a load restarts the burst at beat zero
  p_load_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadAddr |=> beatCnt == '0);

  // R10: with no strobe the counter is frozen
  p_freeze_beat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(beatCnt));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advNotLoad,
  input  logic              enLowA,
  input  logic              enHigh,
  input  logic              enLowB,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              burstActive
);

  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clkEn       (clkEn),
    .advNotLoad  (advNotLoad),
    .enLowA      (enLowA),
    .enHigh      (enHigh),
    .enLowB      (enLowB),
    .strobes     (strobes),
    .burstActive (burstActive)
  );

  burst_seq_datapath #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .interleave (interleave),
    .extAddr    (extAddr),
    .curAddr    (curAddr)
  );

  // R3: a selected load shows the captured address next cycle
  p_load_visible_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advNotLoad && !enLowA && enHigh && !enLowB && $stable(interleave))
      |=> burstActive);

  // R4: advances never disturb the upper address bits
  p_upper_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advNotLoad) |=> $stable(curAddr[ADDR_W-1:BEAT_W]));

  // R8: deselect keeps the upper address
  p_deselect_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advNotLoad && enLowB) |=> $stable(curAddr[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          clkEn, advNotLoad, enLowA, enHigh, enLowB, interleave;
  logic [AW-1:0] extAddr;
  logic [AW-1:0] curAddr;
  logic          burstActive;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int mBase;
  int mBeat;
  bit mActive;

  burst_seq_top #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advNotLoad(advNotLoad),
    .enLowA(enLowA), .enHigh(enHigh), .enLowB(enLowB),
    .interleave(interleave), .extAddr(extAddr),
    .curAddr(curAddr), .burstActive(burstActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expAddr();
    int s;
    int low;
    s = mBase % 4;
    if (interleave) low = s ^ mBeat;
    else            low = (s + mBeat) % 4;
    return (mBase - s) + low;
  endfunction

  task automatic check(input string tag);
    int e;
    e = expAddr();
    checks++;
    if (burstActive !== mActive || curAddr !== AW'(e)) begin
      errors++;
      $display("FAIL %s: active=%0d addr=%h expected active=%0d addr=%h",
               tag, burstActive, curAddr, mActive, AW'(e));
    end
  endtask

  task automatic cycle(input bit ce, input bit adv, input bit a, input bit h,
                       input bit b, input int addr, input string tag);
    int nBase, nBeat;
    bit nActive;
    clkEn = ce; advNotLoad = adv; enLowA = a; enHigh = h; enLowB = b;
    extAddr = AW'(addr);
    nBase = mBase; nBeat = mBeat; nActive = mActive;
    if (ce) begin
      if (!adv) begin
        if (!a && h && !b) begin
          nBase = addr; nBeat = 0; nActive = 1;
        end else begin
          nActive = 0;
        end
      end else if (mActive) begin
        nBeat = (mBeat + 1) % 4;
      end
    end
    @(posedge clk);
    @(negedge clk);
    mBase = nBase; mBeat = nBeat; mActive = nActive;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; clkEn = 1'b1; advNotLoad = 1'b0; enLowA = 1'b0;
    enHigh = 1'b1; enLowB = 1'b0; interleave = 1'b0; extAddr = AW'(32'h5A5A6);
    mBase = 0; mBeat = 0; mActive = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rstN = 1'b1;
    check("R1 after release");

    // linear, start 2: 2,3,0,1 then wrap
    cycle(1, 0, 0, 1, 0, 32'hABCD6, "R3 load");
    for (int i = 0; i < 6; i++) cycle(1, 1, 0, 1, 0, 0, "R5 linear step / R7 wrap");
    // R4: upper bits unchanged after wrap
    checks++;
    if (curAddr[AW-1:2] !== 18'(32'hABCD6 >> 2)) begin
      errors++;
      $display("FAIL R4: upper=%h expected %h", curAddr[AW-1:2], 18'(32'hABCD6 >> 2));
    end

    // interleaved, start 1: 1,0,3,2 then wrap
    interleave = 1'b1;
    cycle(1, 0, 0, 1, 0, 32'h12345, "R3 load interleaved");
    for (int i = 0; i < 5; i++) cycle(1, 1, 0, 1, 0, 0, "R6 interleaved step / R7 wrap");

    // R11: toggle order mid-burst, no clock
    interleave = 1'b0; #1; check("R11 mode to linear");
    interleave = 1'b1; #1; check("R11 mode to interleaved");

    // R2/R8: each enable dropped on its own
    cycle(1, 0, 1, 1, 0, 32'h77777, "R2 enLowA high deselects / R8");
    cycle(1, 1, 0, 1, 0, 0, "R9 advance while idle");
    cycle(1, 0, 0, 1, 0, 32'h00003, "R3 reload");
    cycle(1, 0, 0, 0, 0, 32'h44444, "R2 enHigh low deselects / R8");
    cycle(1, 0, 0, 1, 0, 32'h00002, "R3 reload");
    cycle(1, 1, 0, 1, 0, 0, "R4 step");
    cycle(1, 0, 0, 1, 1, 32'h99999, "R2 enLowB high deselects / R8");
    cycle(1, 1, 0, 1, 0, 0, "R9 advance while idle");

    // R10: frozen edges ignore load and advance
    cycle(1, 0, 0, 1, 0, 32'h0F0F1, "R3 load");
    cycle(1, 1, 0, 1, 0, 0, "R4 step");
    cycle(0, 0, 0, 1, 0, 32'hFFFFF, "R10 load ignored while frozen");
    cycle(0, 1, 0, 1, 0, 0, "R10 advance ignored while frozen");
    cycle(0, 0, 1, 0, 1, 0, "R10 deselect ignored while frozen");
    cycle(1, 1, 0, 1, 0, 0, "R4 step after freeze");

    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      bit sel;
      sel = ($urandom % 5) != 0;
      if (($urandom % 50) == 0) interleave = ~interleave;
      cycle(($urandom % 7) != 0, ($urandom % 3) != 0,
            sel ? 1'b0 : 1'($urandom), sel ? 1'b1 : 1'($urandom),
            sel ? 1'b0 : 1'b1, int'($urandom % (1 << AW)),
            "R4/R5/R6/R8/R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule